// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block collects every interrupt source of a PCIe root port into one local status word and drives a single level-sensitive interrupt line to the CPU. Four legacy INTx wires, six error event inputs (three from the AXI side and three from the PCIe side) and a summary of captured message-signalled interrupts each own a fixed bit of that word. A local mask register selects which of those bits may raise the CPU line.

The MSI capture unit is part of the block. It compares every inbound memory write against a programmable target address. When the address matches, it takes the write data as a vector number and sets the matching bit of a 32-bit MSI status register. Software reaches all four registers over a simple 32-bit register bus. Reads have no side effects. Both status registers are write-one-to-clear, and an event that arrives in the same cycle as a clear is never dropped.

Top module: `rp_irq_agg`

## Requirements
- R1: Synchronous reset clears the mask register, the MSI target address, the local status word and the MSI status register, and holds `cpu_irq` low.
- R2: Register offsets are mask 0x180, local status 0x184, MSI target address 0x190 and MSI status 0x194. The mask and the target address read back exactly as written. Any other offset reads as zero.
- R3: An inbound write whose address equals the target address and whose data is a value n below 32 sets bit n of the MSI status register at the clock edge that samples it.
- R4: An inbound write whose data is 32 or more, or whose address differs from the target address, changes no MSI status bit.
- R5: Writing 1 to an MSI status bit clears it and writing 0 leaves it alone. If a new event for that bit arrives in the same cycle as the clear, the bit stays set.
- R6: A rising edge on error input k (k = 0..5: AXI post, AXI fetch, AXI discard, PCIe post, PCIe fetch, PCIe discard) sets local status bit 16, 17, 18, 20, 21 or 22 respectively. The bit stays set until it is written with 1, and a new rising edge wins over a clear in the same cycle. An input held high sets the bit only once.
- R7: Local status bits 24 to 27 (INTA to INTD) follow the level of their lines one cycle later, and writing 1 to them has no effect while the line is asserted.
- R8: Bit 28 of the local status word sets one cycle after any MSI status bit is set. It stays set until it is written with 1. Clearing it while any MSI status bit is still pending leaves it set.
- R9: `cpu_irq` is high exactly when a local status bit at positions 16–18, 20–22 or 24–28 is set together with its mask bit. A mask of 0 holds it low, and mask bits at undefined positions have no effect. Undefined status bits read as zero.
- R10: Writing 0xFFFFFFFF to the local status register clears every error bit and the summary bit in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| intx_lvl | input | 4 | Legacy interrupt lines INTA..INTD, active high |
| err_evt | input | 6 | Error event inputs, edge captured |
| ib_wr_valid | input | 1 | An inbound memory write is present |
| ib_wr_addr | input | 32 | Inbound write address |
| ib_wr_data | input | 32 | Inbound write data (MSI vector) |
| cpu_irq | output | 1 | Level interrupt to the CPU |

## Verification
The bench targets the following cases, and each one exposes a specific class of bug:
- An MSI event that lands in the same cycle as its W1C write. A design that gives the clear priority loses the interrupt.
- Vectors of 32 or more, and writes to a neighbouring address. A design that truncates the vector or compares too few address bits sets a spurious MSI bit.
- A held error input cleared while still high. A level-captured design re-sets the bit at once, where an edge-captured design does not.
- An INTx line cleared while still asserted. A design that treats these bits as sticky loses the level and shows a wrong readback.
- A summary bit cleared with MSI vectors still pending. A design that stops re-arming it goes silent with work outstanding.
- Mask values that are zero, single-bit, or set only at undefined positions. A design that ignores the defined-bit filter raises `cpu_irq` when it must stay low.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;

    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] OFF_MASK    = 12'h180;
    localparam logic [AW-1:0] OFF_STAT    = 12'h184;
    localparam logic [AW-1:0] OFF_MSIADDR = 12'h190;
    localparam logic [AW-1:0] OFF_MSISTAT = 12'h194;

    localparam int N_ERR    = 6;
    localparam int N_INTX   = 4;
    localparam int INTX_LSB = 24;
    localparam int SUM_BIT  = 28;

    // error k -> status position: AXI side 16..18, PCIe side 20..22
    function automatic int err_pos(input int k);
        return (k < 3) ? 16 + k : 17 + k;
    endfunction

    function automatic logic [DW-1:0] defined_bits();
        logic [DW-1:0] m;
        m = '0;
        for (int k = 0; k < N_ERR; k++) m[err_pos(k)] = 1'b1;
        for (int k = 0; k < N_INTX; k++) m[INTX_LSB + k] = 1'b1;
        m[SUM_BIT] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } ib_wr_t;

    typedef struct packed {
        logic mask_we;
        logic stat_we;
        logic taddr_we;
        logic mstat_we;
    } reg_sel_t;

endpackage

// File: rtl/rp_irq_regs.sv
module rp_irq_regs
    import rp_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] stat,
    input  logic [DW-1:0] msistat,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] taddr_q,
    output logic [DW-1:0] stat_clr,
    output logic [DW-1:0] msi_clr,
    output logic [DW-1:0] rdata
);
    reg_sel_t sel;

    always_comb begin
        sel          = '0;
        sel.mask_we  = bus_wr && (bus_addr == OFF_MASK);
        sel.stat_we  = bus_wr && (bus_addr == OFF_STAT);
        sel.taddr_we = bus_wr && (bus_addr == OFF_MSIADDR);
        sel.mstat_we = bus_wr && (bus_addr == OFF_MSISTAT);
    end

    assign stat_clr = sel.stat_we  ? bus_wdata : '0;
    assign msi_clr  = sel.mstat_we ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            taddr_q <= '0;
        end else begin
            if (sel.mask_we)  mask_q  <= bus_wdata;
            if (sel.taddr_we) taddr_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFF_MASK:    rdata = mask_q;
            OFF_STAT:    rdata = stat;
            OFF_MSIADDR: rdata = taddr_q;
            OFF_MSISTAT: rdata = msistat;
            default:     rdata = '0;
        endcase
    end

    // R2: a write to the mask offset is visible on the next cycle
    a_r2_mask_written: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_MASK) |=> (mask_q == $past(bus_wdata)));

endmodule

// File: rtl/rp_irq_msi_capture.sv
module rp_irq_msi_capture
    import rp_irq_pkg::*;
#(
    parameter  int VECTORS = 32,
    localparam int VW      = $clog2(VECTORS)
) (
    input  logic               clk,
    input  logic               rst,
    input  ib_wr_t             ib,
    input  logic [DW-1:0]      target,
    input  logic [VECTORS-1:0] clr,
    output logic [VECTORS-1:0] pend,
    output logic               any_pend
);
    logic          hit;
    logic [VW-1:0] vec;

    assign vec      = ib.data[VW-1:0];
    assign hit      = ib.valid && (ib.addr == target) && ((ib.data >> VW) == '0);
    assign any_pend = |pend;

    for (genvar v = 0; v < VECTORS; v++) begin : g_vec
        logic set_v;
        assign set_v = hit && (vec == VW'(v));
        always_ff @(posedge clk) begin
            if (rst) pend[v] <= 1'b0;
            else     pend[v] <= (pend[v] && !clr[v]) || set_v;
        end
    end

    // R3: a matching write marks its vector pending
    a_r3_vector_sets: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend[$past(vec)]);

    // R4: without a hit no new bit appears
    a_r4_miss_no_set: assert property (@(posedge clk) disable iff (rst)
        !hit |=> ((pend & ~$past(pend)) == '0));

    // R5: a cleared bit without a new event drops
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (!hit && (clr & pend) != '0) |=> ((pend & $past(clr)) == '0));

endmodule

// File: rtl/rp_irq_local_status.sv
module rp_irq_local_status
    import rp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_ERR-1:0]  err_evt,
    input  logic [N_INTX-1:0] intx_lvl,
    input  logic              msi_any,
    input  logic [DW-1:0]     clr,
    output logic [DW-1:0]     stat
);
    logic [N_ERR-1:0]  err_prev;
    logic [N_ERR-1:0]  err_q;
    logic [N_ERR-1:0]  err_clr;
    logic [N_INTX-1:0] intx_q;
    logic              sum_q;

    for (genvar k = 0; k < N_ERR; k++) begin : g_err
        localparam int P = err_pos(k);
        logic rise;
        assign err_clr[k] = clr[P];
        assign rise       = err_evt[k] && !err_prev[k];
        always_ff @(posedge clk) begin
            if (rst) err_q[k] <= 1'b0;
            else     err_q[k] <= (err_q[k] && !err_clr[k]) || rise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_prev <= '0;
            intx_q   <= '0;
            sum_q    <= 1'b0;
        end else begin
            err_prev <= err_evt;
            intx_q   <= intx_lvl;
            sum_q    <= (sum_q && !clr[SUM_BIT]) || msi_any;
        end
    end

    always_comb begin
        stat = '0;
        for (int k = 0; k < N_ERR; k++) stat[err_pos(k)] = err_q[k];
        stat[INTX_LSB +: N_INTX] = intx_q;
        stat[SUM_BIT]            = sum_q;
    end

    // R6: a set error bit only falls through a write of 1
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(err_q) & ~$past(err_clr)) & ~err_q) == '0));

    // R7: INTx bits track the lines with one cycle of delay
    a_r7_intx_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat[INTX_LSB +: N_INTX] == $past(intx_lvl)));

    // R8: pending MSI work keeps the summary bit up
    a_r8_summary_rearm: assert property (@(posedge clk) disable iff (rst)
        msi_any |=> stat[SUM_BIT]);

endmodule

// File: rtl/rp_irq_agg.sv
module rp_irq_agg
    import rp_irq_pkg::*;
#(
    parameter int MSI_VECTORS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_INTX-1:0] intx_lvl,
    input  logic [N_ERR-1:0]  err_evt,
    input  logic              ib_wr_valid,
    input  logic [DW-1:0]     ib_wr_addr,
    input  logic [DW-1:0]     ib_wr_data,
    output logic              cpu_irq
);
    localparam logic [DW-1:0] DEF_BITS = defined_bits();

    ib_wr_t                 ib;
    logic [DW-1:0]          mask_q, taddr_q, stat_clr, msi_clr, stat, msistat;
    logic [MSI_VECTORS-1:0] msi_pend;
    logic                   msi_any;

    assign ib      = '{valid: ib_wr_valid, addr: ib_wr_addr, data: ib_wr_data};
    assign msistat = DW'(msi_pend);

    rp_irq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .stat     (stat),
        .msistat  (msistat),
        .mask_q   (mask_q),
        .taddr_q  (taddr_q),
        .stat_clr (stat_clr),
        .msi_clr  (msi_clr),
        .rdata    (bus_rdata)
    );

    rp_irq_msi_capture #(.VECTORS(MSI_VECTORS)) u_msi (
        .clk     (clk),
        .rst     (rst),
        .ib      (ib),
        .target  (taddr_q),
        .clr     (msi_clr[MSI_VECTORS-1:0]),
        .pend    (msi_pend),
        .any_pend(msi_any)
    );

    rp_irq_local_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .err_evt (err_evt),
        .intx_lvl(intx_lvl),
        .msi_any (msi_any),
        .clr     (stat_clr),
        .stat    (stat)
    );

    assign cpu_irq = |(stat & mask_q & DEF_BITS);

    // R1: the cycle after reset everything is clear and the line is low
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (stat == '0 && msistat == '0 && mask_q == '0 && !cpu_irq));

    // R9: a zero mask keeps the CPU line low
    a_r9_mask_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !cpu_irq);

    // R9: undefined status positions never read as set
    a_r9_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (stat & ~DEF_BITS) == '0);

endmodule

// File: tb/tb_rp_irq_agg.sv
module tb_rp_irq_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  intx_lvl = '0;
    logic [5:0]  err_evt = '0;
    logic        ib_wr_valid = 1'b0;
    logic [31:0] ib_wr_addr = '0;
    logic [31:0] ib_wr_data = '0;
    logic        cpu_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    rp_irq_agg dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intx_lvl(intx_lvl),
        .err_evt(err_evt), .ib_wr_valid(ib_wr_valid), .ib_wr_addr(ib_wr_addr),
        .ib_wr_data(ib_wr_data), .cpu_irq(cpu_irq)
    );

    // ---------------- behavioural reference model ----------------
    int          epos[6] = '{16, 17, 18, 20, 21, 22};
    logic [31:0] m_mask, m_addr, m_msi;
    logic [5:0]  m_err, m_eprev;
    logic [3:0]  m_intx;
    logic        m_sum;

    function automatic logic [31:0] m_stat();
        logic [31:0] s = '0;
        for (int k = 0; k < 6; k++) s[epos[k]] = m_err[k];
        for (int k = 0; k < 4; k++) s[24 + k] = m_intx[k];
        s[28] = m_sum;
        return s;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h180: return m_mask;
            12'h184: return m_stat();
            12'h190: return m_addr;
            12'h194: return m_msi;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_irq();
        return (m_stat() & m_mask) != 0;
    endfunction

    always @(posedge clk) begin
        logic [31:0] cs, cm, setm;
        logic        new_sum;
        if (rst) begin
            m_mask = '0; m_addr = '0; m_msi = '0;
            m_err = '0; m_eprev = '0; m_intx = '0; m_sum = 1'b0;
        end else begin
            cs = (bus_wr && bus_addr == 12'h184) ? bus_wdata : 32'h0;
            cm = (bus_wr && bus_addr == 12'h194) ? bus_wdata : 32'h0;
            setm = 32'h0;
            if (ib_wr_valid && ib_wr_addr == m_addr && ib_wr_data < 32)
                setm[ib_wr_data[4:0]] = 1'b1;
            new_sum = (m_sum && !cs[28]) || (m_msi != 0);
            for (int k = 0; k < 6; k++) begin
                if (err_evt[k] && !m_eprev[k]) m_err[k] = 1'b1;
                else if (cs[epos[k]])          m_err[k] = 1'b0;
            end
            m_eprev = err_evt;
            m_intx  = intx_lvl;
            m_sum   = new_sum;
            m_msi   = (m_msi & ~cm) | setm;
            if (bus_wr && bus_addr == 12'h180) m_mask = bus_wdata;
            if (bus_wr && bus_addr == 12'h190) m_addr = bus_wdata;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: CPU line compared with the model every cycle
    always @(negedge clk) begin
        if (!rst && !done) chk("R9 cpu_irq per cycle", 32'(cpu_irq), 32'(m_irq()));
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        bus_addr = a;
        #2;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic msi(input logic [31:0] a, input logic [31:0] d);
        ib_wr_valid = 1'b1; ib_wr_addr = a; ib_wr_data = d;
        step();
        ib_wr_valid = 1'b0;
    endtask

    localparam logic [31:0] TGT = 32'hFEE0_1000;

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);
        bus_addr = 12'h184; #2; chk("R1 status zero", bus_rdata, 32'h0);
        rd(12'h180, "R1 mask zero");
        rd(12'h190, "R1 target zero");
        rd(12'h194, "R1 msi status zero");

        // R2 register map
        wr(12'h180, 32'hFFFF_FFFF);
        rd(12'h180, "R2 mask readback");
        wr(12'h190, TGT);
        bus_addr = 12'h190; #2; chk("R2 target readback", bus_rdata, TGT);
        rd(12'h188, "R2 unmapped offset");

        // R3 vector capture
        msi(TGT, 32'd5);
        bus_addr = 12'h194; #2; chk("R3 vector 5", bus_rdata, 32'h0000_0020);
        msi(TGT, 32'd31);
        msi(TGT, 32'd0);
        rd(12'h194, "R3 vectors 0 5 31");

        // R4 ignored writes
        msi(TGT, 32'd32);
        msi(TGT + 4, 32'd3);
        msi(32'h0, 32'd7);
        rd(12'h194, "R4 bad vector or address");

        // R5 clear and collision
        wr(12'h194, 32'h0000_0020);
        rd(12'h194, "R5 single clear");
        bus_wr = 1'b1; bus_addr = 12'h194; bus_wdata = 32'h8000_0000;
        ib_wr_valid = 1'b1; ib_wr_addr = TGT; ib_wr_data = 32'd31;
        step();
        bus_wr = 1'b0; ib_wr_valid = 1'b0;
        bus_addr = 12'h194; #2; chk("R5 event beats clear", bus_rdata, 32'h8000_0001);

        // R8 summary
        rd(12'h184, "R8 summary set");
        wr(12'h184, 32'h1000_0000);
        step();
        rd(12'h184, "R8 clear while pending");
        wr(12'h194, 32'hFFFF_FFFF);
        step(); step();
        rd(12'h184, "R8 sticky after msi drained");
        wr(12'h184, 32'h1000_0000);
        step();
        bus_addr = 12'h184; #2; chk("R8 summary cleared", bus_rdata, 32'h0);

        // R6 errors
        err_evt = 6'b111111; step(); err_evt = '0;
        bus_addr = 12'h184; #2; chk("R6 all error bits", bus_rdata, 32'h0077_0000);
        wr(12'h184, 32'h0001_0000);
        rd(12'h184, "R6 clear one");
        err_evt = 6'b000100; step(); step();
        wr(12'h184, 32'h0004_0000);
        step();
        rd(12'h184, "R6 held input sets once");
        err_evt = '0; step();
        err_evt = 6'b000100; step(); err_evt = '0;
        rd(12'h184, "R6 new edge sets again");
        bus_wr = 1'b1; bus_addr = 12'h184; bus_wdata = 32'h0010_0000; err_evt = 6'b001000;
        step();
        bus_wr = 1'b0; err_evt = '0;
        rd(12'h184, "R6 edge beats clear");

        // R7 INTx level
        intx_lvl = 4'b1010; step(); step();
        rd(12'h184, "R7 level visible");
        wr(12'h184, 32'hFFFF_FFFF);
        bus_addr = 12'h184; #2; chk("R7 cannot clear asserted line", bus_rdata[27:24], 32'ha);
        chk("R10 all ones clears sticky", bus_rdata & 32'h1077_0000, 32'h0);
        intx_lvl = '0; step();
        rd(12'h184, "R7 deasserted");

        // R9 masking
        err_evt = 6'b000001; step(); err_evt = '0;
        wr(12'h180, 32'h0);
        chk("R9 zero mask", 32'(cpu_irq), 32'h0);
        wr(12'h180, 32'h0080_0000);
        chk("R9 undefined mask bit", 32'(cpu_irq), 32'h0);
        wr(12'h180, 32'h0100_0000);
        intx_lvl = 4'b0001; step(); step();
        chk("R9 INTA unmasked", 32'(cpu_irq), 32'h1);
        intx_lvl = '0; step();
        wr(12'h184, 32'hFFFF_FFFF);
        rd(12'h184, "R10 status empty");

        // mixed random traffic against the model
        for (int k = 0; k < 1500; k++) begin
            logic [11:0] offs[4] = '{12'h180, 12'h184, 12'h190, 12'h194};
            err_evt     = ($urandom % 8 == 0) ? 6'($urandom) : 6'h0;
            if ($urandom % 16 == 0) intx_lvl = 4'($urandom);
            ib_wr_valid = ($urandom % 3 == 0);
            ib_wr_addr  = ($urandom % 5 == 0) ? 32'($urandom) : m_addr;
            ib_wr_data  = 32'($urandom % 40);
            bus_wr      = ($urandom % 6 == 0);
            bus_addr    = offs[(($urandom % 10) == 0) ? 2 : ($urandom % 2) * 3 + 0 + (($urandom % 2) ? 1 : 0)];
            bus_wdata   = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : 32'($urandom);
            #2;
            chk("R2 random readback", bus_rdata, m_read(bus_addr));
            step();
        end
        bus_wr = 1'b0; ib_wr_valid = 1'b0; err_evt = '0; intx_lvl = '0;
        step(); step();
        rd(12'h194, "R3 after random traffic");
        rd(12'h184, "R6 after random traffic");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule